// File: doc/BRIEF.md
# DRAM Clock-Stop Sequencer

This block sits between the command scheduler of a low-power DDR memory controller and the memory clock outputs. When the scheduler asks to save power, the block first waits until no operation would be disturbed by a stopped clock. That means every command timing interval has expired, no read or write burst is still moving, and the scheduler has nothing queued. Only then does it stop the memory clock. While stopped it holds the clock pair and the clock-enable pin at fixed levels.

On a wake request the clock restarts at once. The block then forces a configurable number of no-operation cycles before the scheduler may issue commands again. Any command is legal after that gap, because clock-enable is never lowered. The block also raises a flag that tells the clock generator when a frequency change would be safe. While the clock runs, the block forwards scheduler commands to the memory through one register stage.

Top module: `clkstop_seq`

## Requirements
- R1: `stopped` rises only one cycle after a clock edge at which all `NUM_TMR` bits of `tmr_done` were high, `burst_busy` was low, `sched_idle` was high and `sched_valid` was low. While any of these conditions fails, the block keeps waiting and `stopped` stays low.
- R2: A single-cycle pulse on `stop_req` in the running state is remembered. The block stops later, once the conditions of R1 hold, without `stop_req` being asserted again.
- R3: While `stopped` is high, all of the following hold: `clk_en` is 0, `ck_lvl` is 0, `ckn_lvl` is 1 and `cke` is 1. These levels do not change until the block wakes.
- R4: `stopped` is high only in the stopped state. It falls in the cycle after `wake_req` is sampled.
- R5: `sched_ready` is low while stopped and during the restart gap. While `sched_ready` is low, `mem_cmd` carries the no-operation code 3'b111.
- R6: After a wake, `clk_en` is 1 and `sched_ready` stays low for exactly `NOP_CYC` cycles (at least 1). The first command accepted after that appears on `mem_cmd` one cycle later.
- R7: In the running state, a command accepted at a clock edge (`sched_valid` and `sched_ready` both high) appears on `mem_cmd` in the following cycle. With no command accepted, `mem_cmd` is 3'b111.
- R8: A `wake_req` sampled while the block is waiting to stop cancels the stop, even if the stop conditions hold at that same edge. The block returns to running with `stopped` low and `sched_ready` high.
- R9: `freq_ok` is high exactly when, at the previous edge, all `tmr_done` bits were high and `burst_busy` was low.
- R10: Synchronous reset puts the block in the running state with `cke`=0, `ck_lvl`=0, `ckn_lvl`=1, `mem_cmd`=3'b111, `stopped`=0 and `freq_ok`=0. `cke` goes to 1 at the first edge after reset.
- R11: While the clock runs and the block is not stopped, `ck_lvl` toggles on every edge and `ckn_lvl` is always its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Request to stop the memory clock |
| wake_req | input | 1 | Request to restart the memory clock |
| tmr_done | input | NUM_TMR | Per-interval expiry flags (refresh, mode-set, write recovery, activate, precharge, postamble) |
| burst_busy | input | 1 | A read or write burst is still in flight |
| sched_idle | input | 1 | Scheduler has no queued work |
| sched_valid | input | 1 | Scheduler presents a command |
| sched_cmd | input | CS_CMD_W | Scheduler command code |
| sched_ready | output | 1 | Command accepted when high together with sched_valid |
| mem_cmd | output | CS_CMD_W | Registered command to the memory, 3'b111 = no-op |
| clk_en | output | 1 | Enable for the memory clock driver |
| ck_lvl | output | 1 | True clock level |
| ckn_lvl | output | 1 | Complement clock level |
| cke | output | 1 | Clock-enable pin level |
| stopped | output | 1 | High only while the clock is stopped |
| freq_ok | output | 1 | A clock frequency change is currently safe |

## Verification
Two events can meet at the same edge while the block waits to stop: the last stop condition comes true, and a wake request arrives. The bench provokes this by leaving every timer expired, pulsing the stop request, and then raising the wake request in the very next cycle, before the stopped state can be reached. It judges the outcome by checking that `stopped` never rises and that `sched_ready` is high again in the following cycle.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;
  localparam int CS_CMD_W = 3;
  localparam logic [CS_CMD_W-1:0] CS_NOP = 3'b111;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_STOP  = 2'd2,
    ST_WAKE  = 2'd3
  } cs_state_e;
endpackage

// File: rtl/cs_qual.sv
`timescale 1ns/1ps
module cs_qual #(
  parameter int NUM_TMR = 6
) (
  input  logic [NUM_TMR-1:0] tmr_done,
  input  logic               burst_busy,
  input  logic               sched_idle,
  input  logic               sched_valid,
  output logic               tim_ok,
  output logic               stop_ok
);
  // running AND over the expiry flags
  logic [NUM_TMR:0] chain;
  assign chain[0] = 1'b1;
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_and
    assign chain[i+1] = chain[i] & tmr_done[i];
  end

  assign tim_ok  = chain[NUM_TMR] & ~burst_busy;
  assign stop_ok = tim_ok & sched_idle & ~sched_valid;
endmodule

// File: rtl/cs_fsm.sv
`timescale 1ns/1ps
module cs_fsm #(
  parameter int NOP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_req,
  input  logic              wake_req,
  input  logic              stop_ok,
  output cs_pkg::cs_state_e state,
  output cs_pkg::cs_state_e nxt
);
  import cs_pkg::*;
  localparam int GAP   = (NOP_CYC < 1) ? 1 : NOP_CYC;
  localparam int CNT_W = $clog2(GAP + 1);
  localparam logic [CNT_W-1:0] GAP_V = CNT_W'(GAP);

  logic [CNT_W-1:0] gap_cnt, gap_nxt;

  always_comb begin
    nxt     = state;
    gap_nxt = gap_cnt;
    case (state)
      ST_RUN:   if (stop_req) nxt = ST_DRAIN;
      ST_DRAIN: begin
        if (wake_req)     nxt = ST_RUN;   // cancel wins over stop
        else if (stop_ok) nxt = ST_STOP;
      end
      ST_STOP: begin
        if (wake_req) begin
          nxt     = ST_WAKE;
          gap_nxt = GAP_V;
        end
      end
      ST_WAKE: begin
        if (gap_cnt <= 1) nxt = ST_RUN;
        else              gap_nxt = gap_cnt - 1'b1;
      end
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RUN;
      gap_cnt <= '0;
    end else begin
      state   <= nxt;
      gap_cnt <= gap_nxt;
    end
  end
endmodule

// File: rtl/cs_pins.sv
`timescale 1ns/1ps
module cs_pins (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        park,
  input  logic                        accept,
  input  logic [cs_pkg::CS_CMD_W-1:0] sched_cmd,
  input  logic                        tim_ok,
  output logic                        ck_lvl,
  output logic                        ckn_lvl,
  output logic                        cke,
  output logic [cs_pkg::CS_CMD_W-1:0] mem_cmd,
  output logic                        freq_ok
);
  import cs_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_lvl  <= 1'b0;
      ckn_lvl <= 1'b1;
      cke     <= 1'b0;
      mem_cmd <= CS_NOP;
      freq_ok <= 1'b0;
    end else begin
      ck_lvl  <= park ? 1'b0 : ~ck_lvl;
      ckn_lvl <= park ? 1'b1 : ~ckn_lvl;
      cke     <= 1'b1;
      mem_cmd <= accept ? sched_cmd : CS_NOP;
      freq_ok <= tim_ok;
    end
  end
endmodule

// File: rtl/clkstop_seq.sv
`timescale 1ns/1ps
module clkstop_seq #(
  parameter int NUM_TMR = 6,
  parameter int NOP_CYC = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        stop_req,
  input  logic                        wake_req,
  input  logic [NUM_TMR-1:0]          tmr_done,
  input  logic                        burst_busy,
  input  logic                        sched_idle,
  input  logic                        sched_valid,
  input  logic [cs_pkg::CS_CMD_W-1:0] sched_cmd,
  output logic                        sched_ready,
  output logic [cs_pkg::CS_CMD_W-1:0] mem_cmd,
  output logic                        clk_en,
  output logic                        ck_lvl,
  output logic                        ckn_lvl,
  output logic                        cke,
  output logic                        stopped,
  output logic                        freq_ok
);
  import cs_pkg::*;

  logic      tim_ok, stop_ok;
  cs_state_e state, nxt;

  cs_qual #(.NUM_TMR(NUM_TMR)) u_qual (
    .tmr_done   (tmr_done),
    .burst_busy (burst_busy),
    .sched_idle (sched_idle),
    .sched_valid(sched_valid),
    .tim_ok     (tim_ok),
    .stop_ok    (stop_ok)
  );

  cs_fsm #(.NOP_CYC(NOP_CYC)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .stop_req(stop_req),
    .wake_req(wake_req),
    .stop_ok (stop_ok),
    .state   (state),
    .nxt     (nxt)
  );

  assign sched_ready = (state == ST_RUN) || (state == ST_DRAIN);
  assign clk_en      = (state != ST_STOP);
  assign stopped     = (state == ST_STOP);

  cs_pins u_pins (
    .clk      (clk),
    .rst      (rst),
    .park     (nxt == ST_STOP),
    .accept   (sched_valid & sched_ready),
    .sched_cmd(sched_cmd),
    .tim_ok   (tim_ok),
    .ck_lvl   (ck_lvl),
    .ckn_lvl  (ckn_lvl),
    .cke      (cke),
    .mem_cmd  (mem_cmd),
    .freq_ok  (freq_ok)
  );
endmodule

// File: rtl/cs_chk.sv
`timescale 1ns/1ps
module cs_chk #(
  parameter int NUM_TMR = 6,
  parameter int NOP_CYC = 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_TMR-1:0]          tmr_done,
  input logic                        burst_busy,
  input logic                        sched_idle,
  input logic                        sched_valid,
  input logic                        sched_ready,
  input logic [cs_pkg::CS_CMD_W-1:0] mem_cmd,
  input logic                        clk_en,
  input logic                        ck_lvl,
  input logic                        ckn_lvl,
  input logic                        cke,
  input logic                        stopped,
  input logic                        freq_ok
);
  import cs_pkg::*;

  logic       live;
  logic [7:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      live     <= 1'b0;
      wait_cnt <= '0;
    end else begin
      live <= 1'b1;
      if (stopped)                              wait_cnt <= '0;
      else if (!sched_ready && wait_cnt != 8'hff) wait_cnt <= wait_cnt + 1'b1;
    end
  end

  assert_stop_qualified_R1: assert property (@(posedge clk) disable iff (rst)
    (live && $rose(stopped)) |->
      $past((&tmr_done) && !burst_busy && sched_idle && !sched_valid));

  assert_parked_levels_R3: assert property (@(posedge clk) disable iff (rst)
    stopped |-> (!clk_en && !ck_lvl && ckn_lvl && cke));

  assert_parked_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (live && stopped && $past(stopped)) |->
      ($stable(ck_lvl) && $stable(ckn_lvl) && $stable(cke)));

  assert_no_accept_stopped_R5: assert property (@(posedge clk) disable iff (rst)
    stopped |-> !sched_ready);

  assert_nop_when_blocked_R5: assert property (@(posedge clk) disable iff (rst)
    (live && !$past(sched_ready)) |-> (mem_cmd == CS_NOP));

  assert_restart_gap_R6: assert property (@(posedge clk) disable iff (rst)
    (live && $rose(sched_ready)) |-> (wait_cnt >= NOP_CYC));

  assert_forward_origin_R7: assert property (@(posedge clk) disable iff (rst)
    (live && mem_cmd != CS_NOP) |-> $past(sched_valid && sched_ready));

  assert_freq_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (live && freq_ok) |-> $past((&tmr_done) && !burst_busy));

  assert_clock_toggle_R11: assert property (@(posedge clk) disable iff (rst)
    (live && !stopped && !$past(stopped)) |->
      (ck_lvl != $past(ck_lvl) && ckn_lvl == !ck_lvl));
endmodule

bind clkstop_seq cs_chk #(.NUM_TMR(NUM_TMR), .NOP_CYC(NOP_CYC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tmr_done   (tmr_done),
  .burst_busy (burst_busy),
  .sched_idle (sched_idle),
  .sched_valid(sched_valid),
  .sched_ready(sched_ready),
  .mem_cmd    (mem_cmd),
  .clk_en     (clk_en),
  .ck_lvl     (ck_lvl),
  .ckn_lvl    (ckn_lvl),
  .cke        (cke),
  .stopped    (stopped),
  .freq_ok    (freq_ok)
);

// File: tb/sim_clkstop_seq.sv
`timescale 1ns/1ps
module sim_clkstop_seq;
  import cs_pkg::*;
  localparam int NT  = 6;
  localparam int GAP = 2;
  localparam logic [NT-1:0] ALL = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req = 1'b0, wake_req = 1'b0;
  logic [NT-1:0] tmr_done = '1;
  logic burst_busy = 1'b0, sched_idle = 1'b1, sched_valid = 1'b0;
  logic [CS_CMD_W-1:0] sched_cmd = 3'b000;
  logic sched_ready, clk_en, ck_lvl, ckn_lvl, cke, stopped, freq_ok;
  logic [CS_CMD_W-1:0] mem_cmd;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  clkstop_seq #(.NUM_TMR(NT), .NOP_CYC(GAP)) u0 (
    .clk(clk), .rst(rst), .stop_req(stop_req), .wake_req(wake_req),
    .tmr_done(tmr_done), .burst_busy(burst_busy), .sched_idle(sched_idle),
    .sched_valid(sched_valid), .sched_cmd(sched_cmd), .sched_ready(sched_ready),
    .mem_cmd(mem_cmd), .clk_en(clk_en), .ck_lvl(ck_lvl), .ckn_lvl(ckn_lvl),
    .cke(cke), .stopped(stopped), .freq_ok(freq_ok)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    chk("R10 cke in reset", cke, 0);
    chk("R10 ck in reset", ck_lvl, 0);
    chk("R10 ckn in reset", ckn_lvl, 1);
    chk("R10 cmd in reset", mem_cmd, CS_NOP);
    chk("R10 stopped in reset", stopped, 0);
    chk("R10 freq_ok in reset", freq_ok, 0);
    rst = 1'b0;
    step();
    chk("R10 cke after reset", cke, 1);
    chk("R10 ready after reset", sched_ready, 1);
  endtask

  task automatic t_forward();
    sched_valid = 1'b1; sched_cmd = 3'b010;
    step();
    chk("R7 forwarded cmd", mem_cmd, 3'b010);
    sched_cmd = 3'b101;
    step();
    chk("R7 second cmd", mem_cmd, 3'b101);
    sched_valid = 1'b0;
    step();
    chk("R7 idle gives nop", mem_cmd, CS_NOP);
  endtask

  task automatic t_toggle();
    logic prev;
    prev = ck_lvl;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R11 ck toggles", ck_lvl, !prev);
      chk("R11 ckn complement", ckn_lvl, !ck_lvl);
      prev = ck_lvl;
    end
  endtask

  task automatic t_delayed_stop();
    tmr_done = ALL & ~NT'(1 << 2);
    stop_req = 1'b1;
    step();
    stop_req = 1'b0;
    chk("R1 not stopped with timer busy", stopped, 0);
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R2 still waiting", stopped, 0);
    end
    tmr_done = ALL; burst_busy = 1'b1;
    step(); step();
    chk("R1 burst holds stop", stopped, 0);
    burst_busy = 1'b0;
    step();
    chk("R1 stop after all expired", stopped, 1);
  endtask

  task automatic t_parked();
    for (int i = 0; i < 6; i++) begin
      if (i == 2) begin sched_valid = 1'b1; sched_cmd = 3'b001; end
      step();
      chk("R3 clk_en low", clk_en, 0);
      chk("R3 ck low", ck_lvl, 0);
      chk("R3 ckn high", ckn_lvl, 1);
      chk("R3 cke high", cke, 1);
      chk("R4 stopped high", stopped, 1);
      chk("R5 ready low while stopped", sched_ready, 0);
      chk("R5 nop while stopped", mem_cmd, CS_NOP);
    end
  endtask

  task automatic t_restart();
    int gap;
    sched_valid = 1'b1; sched_cmd = 3'b011;
    wake_req = 1'b1;
    step();
    wake_req = 1'b0;
    chk("R4 stopped falls after wake", stopped, 0);
    chk("R6 clock enabled on wake", clk_en, 1);
    chk("R5 first restart cycle nop", mem_cmd, CS_NOP);
    gap = 0;
    while (!sched_ready && gap < 20) begin
      gap++;
      chk("R5 nop during gap", mem_cmd, CS_NOP);
      step();
    end
    chk("R6 gap length", gap, GAP);
    chk("R6 nop when ready returns", mem_cmd, CS_NOP);
    step();
    chk("R6 first cmd after gap", mem_cmd, 3'b011);
    sched_valid = 1'b0;
    step();
  endtask

  task automatic t_collision();
    tmr_done = ALL;
    stop_req = 1'b1;
    step();
    stop_req = 1'b0;
    wake_req = 1'b1;
    step();
    wake_req = 1'b0;
    chk("R8 wake cancels stop", stopped, 0);
    chk("R8 ready after cancel", sched_ready, 1);
    step(); step();
    chk("R8 stays running", stopped, 0);
  endtask

  task automatic t_freq();
    tmr_done = ALL & ~NT'(1 << 5);
    step();
    chk("R9 freq_ok low with timer busy", freq_ok, 0);
    tmr_done = ALL; burst_busy = 1'b1;
    step();
    chk("R9 freq_ok low with burst", freq_ok, 0);
    burst_busy = 1'b0;
    step();
    chk("R9 freq_ok high", freq_ok, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_forward();
    t_toggle();
    t_freq();
    t_delayed_stop();
    t_parked();
    t_restart();
    t_collision();
    t_toggle();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule